// File: doc/BRIEF.md
# SPI Master Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. A configuration word carries five items: a full-rate bypass flag, a prescaler count, a period count, a high-time count, and two mode bits (idle polarity and leading-edge launch). Each count is stored as its real value minus one. When bypass is clear, a wide prescaler produces one tick every P system cycles. Each tick advances a short slot counter that wraps after N slots. The clock sits at its active level for the first H slots of each period and at its idle level for the rest. The resulting serial clock frequency is the system clock divided by P times N.

The transaction engine holds `run` high for as long as a transfer is in progress. While `run` is low the clock rests at its idle level, and a pulse on `cfg_load` latches a new configuration. While `run` is high, a load request is ignored. Every change of the clock level comes with a one-cycle strobe in the system clock domain: a launch strobe (drive the next data bit) and a sample strobe (capture the incoming bit). These strobes let the engine stay fully synchronous. When bypass is set, the clock is the system clock itself, gated by `run`, and both strobes fire in every cycle.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset, `sclk` is 0 and neither `launch_stb` nor `sample_stb` is asserted.
- R2: A `cfg_load` pulse while `run` is low latches the configuration. The counts are taken as value minus one: P = `cfg_pre_m1`+1 (1 to 8192), N = `cfg_per_m1`+1 (2 to 64), H = `cfg_hi_m1`+1, with H < N.
- R3: A `cfg_load` pulse while `run` is high has no effect: the running clock and the next transfer both use the previously latched configuration.
- R4: In divided mode, the first leading clock edge appears in the P-th cycle after `run` is first sampled high. Successive leading edges are P*N cycles apart.
- R5: In divided mode, the clock stays at its active level (not `cfg_cpol`) for exactly P*H cycles, from a leading edge to the following trailing edge.
- R6: While `run` is low (from the cycle after it falls), `sclk` equals the latched `cfg_cpol`, and no strobe is asserted.
- R7: In divided mode, each strobe lasts one cycle and coincides with a clock edge. With `cfg_cpha`=0, `sample_stb` marks leading edges and `launch_stb` marks trailing edges; with `cfg_cpha`=1 the roles are swapped. The two strobes are never asserted together.
- R8: With `cfg_bypass`=1 and `run` high, `sclk` equals the system clock XOR `cfg_cpol`, both strobes are asserted in every cycle, and the count fields have no effect.
- R9: Dropping `run` resets the prescaler and the slot counter, so the next transfer again starts with its first leading edge P cycles after `run` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Transfer in progress; clock runs while high |
| cfg_load | input | 1 | Latch the configuration inputs (honoured only while run is low) |
| cfg_bypass | input | 1 | 1: serial clock at the system clock rate |
| cfg_pre_m1 | input | PRE_W (13) | Prescaler value minus one |
| cfg_per_m1 | input | CNT_W (6) | Period slots minus one |
| cfg_hi_m1 | input | CNT_W (6) | Active-level slots minus one |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 1: launch on the leading edge; 0: launch on the trailing edge |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle strobe: drive the next data bit |
| sample_stb | output | 1 | One-cycle strobe: capture the incoming bit |

## Verification
Two events can fall in the same cycle. The first is a configuration load and a running transfer. The bench pulses `cfg_load` with different counts and mode bits part-way through a run. It then judges, by measuring the edge spacing of that run and of a following run that has no new load, that the old configuration stayed in force. The second is launch and sample. In divided mode they must never coincide, which is checked in every cycle of a sweep over prescaler, period, high-time and both mode bits. In bypass they must coincide in every cycle, which is checked together with the `sclk` level on both halves of the system clock.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  // Clock edge event produced by the waveform shaper.
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LEAD  = 2'd1,
    EV_TRAIL = 2'd2
  } edge_ev_t;

  // Launch uses the leading edge when the phase bit is set, otherwise the trailing edge.
  function automatic logic launch_of(input logic cpha, input edge_ev_t ev);
    return cpha ? (ev == EV_LEAD) : (ev == EV_TRAIL);
  endfunction

  function automatic logic sample_of(input logic cpha, input edge_ev_t ev);
    return cpha ? (ev == EV_TRAIL) : (ev == EV_LEAD);
  endfunction

endpackage

// File: rtl/spi_sclk_cfg.sv
module spi_sclk_cfg #(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             bypass_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic             bypass_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] hi_o,
  output logic             cpol_o,
  output logic             cpha_o
);

  logic take;
  assign take = load && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bypass_o <= 1'b0;
      pre_o    <= '0;
      per_o    <= CNT_W'(1);
      hi_o     <= '0;
      cpol_o   <= 1'b0;
      cpha_o   <= 1'b0;
    end else if (take) begin
      bypass_o <= bypass_i;
      pre_o    <= pre_i;
      per_o    <= per_i;
      hi_o     <= hi_i;
      cpol_o   <= cpol_i;
      cpha_o   <= cpha_i;
    end
  end

endmodule

// File: rtl/spi_sclk_prescale.sv
module spi_sclk_prescale #(
  parameter int PRE_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_m1,
  output logic             tick
);

  logic [PRE_W-1:0] cnt;

  assign tick = en && (cnt == pre_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + PRE_W'(1);
  end

endmodule

// File: rtl/spi_sclk_shaper.sv
module spi_sclk_shaper
  import spi_sclk_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_m1,
  input  logic [CNT_W-1:0] hi_m1,
  output logic             active,
  output edge_ev_t         ev
);

  localparam int EXT_W = CNT_W + 1;

  logic             started;
  logic [CNT_W-1:0] slot;
  logic [CNT_W-1:0] slot_nx;

  // First tick of a transfer opens slot 0; later ticks step and wrap at the period end.
  function automatic logic [CNT_W-1:0] next_slot(input logic st,
                                                 input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] last);
    if (!st)          return '0;
    else if (cur == last) return '0;
    else              return cur + CNT_W'(1);
  endfunction

  function automatic edge_ev_t slot_event(input logic [CNT_W-1:0] s,
                                          input logic [CNT_W-1:0] hi);
    if (s == '0)                                  return EV_LEAD;
    else if ({1'b0, s} == ({1'b0, hi} + EXT_W'(1))) return EV_TRAIL;
    else                                          return EV_NONE;
  endfunction

  assign slot_nx = next_slot(started, slot, per_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      slot    <= '0;
      active  <= 1'b0;
      ev      <= EV_NONE;
    end else if (!en) begin
      started <= 1'b0;
      slot    <= '0;
      active  <= 1'b0;
      ev      <= EV_NONE;
    end else if (tick) begin
      started <= 1'b1;
      slot    <= slot_nx;
      active  <= (slot_nx <= hi_m1);
      ev      <= slot_event(slot_nx, hi_m1);
    end else begin
      ev      <= EV_NONE;
    end
  end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_load,
  input  logic             cfg_bypass,
  input  logic [PRE_W-1:0] cfg_pre_m1,
  input  logic [CNT_W-1:0] cfg_per_m1,
  input  logic [CNT_W-1:0] cfg_hi_m1,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  output logic             sclk,
  output logic             launch_stb,
  output logic             sample_stb
);

  // Latched configuration, brought out as named wires for the checker.
  logic             byp_w;
  logic [PRE_W-1:0] pre_w;
  logic [CNT_W-1:0] per_w;
  logic [CNT_W-1:0] hi_w;
  logic             pol_w;
  logic             pha_w;

  logic     div_run_w;
  logic     tick_w;
  logic     lvl_w;
  edge_ev_t ev_w;
  logic     byp_stb_q;

  spi_sclk_cfg #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run(run), .load(cfg_load),
    .bypass_i(cfg_bypass), .pre_i(cfg_pre_m1), .per_i(cfg_per_m1),
    .hi_i(cfg_hi_m1), .cpol_i(cfg_cpol), .cpha_i(cfg_cpha),
    .bypass_o(byp_w), .pre_o(pre_w), .per_o(per_w), .hi_o(hi_w),
    .cpol_o(pol_w), .cpha_o(pha_w)
  );

  assign div_run_w = run && !byp_w;

  spi_sclk_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(div_run_w), .pre_m1(pre_w), .tick(tick_w)
  );

  spi_sclk_shaper #(.CNT_W(CNT_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .en(div_run_w), .tick(tick_w),
    .per_m1(per_w), .hi_m1(hi_w), .active(lvl_w), .ev(ev_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_stb_q <= 1'b0;
    else        byp_stb_q <= run && byp_w;
  end

  assign sclk       = (byp_w && run) ? (clk ^ pol_w) : (pol_w ^ lvl_w);
  assign launch_stb = byp_stb_q || launch_of(pha_w, ev_w);
  assign sample_stb = byp_stb_q || sample_of(pha_w, ev_w);

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             launch_stb,
  input logic             sample_stb,
  input logic             byp_w,
  input logic             lvl_w,
  input logic [PRE_W-1:0] pre_w,
  input logic [CNT_W-1:0] per_w,
  input logic [CNT_W-1:0] hi_w,
  input logic             pol_w,
  input logic             pha_w
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3: configuration held still while a transfer runs
  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(pre_w) && $stable(per_w) && $stable(hi_w) &&
             $stable(byp_w) && $stable(pol_w) && $stable(pha_w)));

  // R6: idle level and no strobes once run is low
  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!lvl_w && !launch_stb && !sample_stb));

  // R7: launch and sample never together in divided mode
  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_w |-> !(launch_stb && sample_stb));

  // R7: every level change while running carries a strobe
  assert_edge_has_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(run) && (lvl_w != $past(lvl_w))) |-> (launch_stb || sample_stb));

  // R7: a divided-mode strobe lasts one cycle
  assert_launch_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp_w && launch_stb) |=> !launch_stb);

endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .launch_stb(launch_stb),
  .sample_stb(sample_stb), .byp_w(byp_w), .lvl_w(lvl_w), .pre_w(pre_w),
  .per_w(per_w), .hi_w(hi_w), .pol_w(pol_w), .pha_w(pha_w)
);

// File: tb/test_spi_sclk_gen.sv
`timescale 1ns/1ps
module test_spi_sclk_gen;

  localparam int PRE_W = 13;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic             cfg_load = 1'b0;
  logic             cfg_bypass = 1'b0;
  logic [PRE_W-1:0] cfg_pre_m1 = '0;
  logic [CNT_W-1:0] cfg_per_m1 = '0;
  logic [CNT_W-1:0] cfg_hi_m1 = '0;
  logic             cfg_cpol = 1'b0;
  logic             cfg_cpha = 1'b0;
  logic             sclk, launch_stb, sample_stb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_sclk_gen #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_spi_sclk_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_load(cfg_load),
    .cfg_bypass(cfg_bypass), .cfg_pre_m1(cfg_pre_m1), .cfg_per_m1(cfg_per_m1),
    .cfg_hi_m1(cfg_hi_m1), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .sclk(sclk), .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input bit byp, input int pm1, input int nm1, input int hm1,
                          input bit pol, input bit pha);
    @(negedge clk);
    cfg_bypass = byp; cfg_pre_m1 = PRE_W'(pm1); cfg_per_m1 = CNT_W'(nm1);
    cfg_hi_m1 = CNT_W'(hm1); cfg_cpol = pol; cfg_cpha = pha; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // One divided-mode transfer; expectations come from P, N, H and the mode bits.
  task automatic div_run(input int pm1, input int nm1, input int hm1,
                         input bit pol, input bit pha, input bit inject);
    int p = pm1 + 1;
    int n = nm1 + 1;
    int h = hm1 + 1;
    int lead1 = 0, lead2 = 0, trail1 = 0, act_cnt = 0, both = 0;
    bit lead, trail;
    run = 1'b1;
    for (int t = 1; t <= p * (n + 1); t++) begin
      @(negedge clk);
      cfg_load = 1'b0;
      lead  = pha ? launch_stb : sample_stb;
      trail = pha ? sample_stb : launch_stb;
      if (launch_stb && sample_stb) both++;
      if (lead) begin
        if (lead1 == 0) lead1 = t;
        else if (lead2 == 0) lead2 = t;
      end
      if (trail && trail1 == 0) trail1 = t;
      if (lead1 != 0 && lead2 == 0 && sclk != pol) act_cnt++;
      if (inject && t == 2) begin
        // R3: load attempt mid-transfer with different fields
        cfg_bypass = 1'b1; cfg_pre_m1 = PRE_W'(pm1 + 3); cfg_per_m1 = CNT_W'(nm1 + 2);
        cfg_hi_m1 = '0; cfg_cpol = ~pol; cfg_cpha = ~pha; cfg_load = 1'b1;
      end
    end
    check(lead1 == p, inject ? "R3 first lead" : "R4 first lead", lead1, p);
    check(lead2 - lead1 == p * n, inject ? "R3 period" : "R4 period", lead2 - lead1, p * n);
    check(trail1 - lead1 == p * h, "R5 trail position", trail1 - lead1, p * h);
    check(act_cnt == p * h, "R5 active cycles", act_cnt, p * h);
    check(both == 0, "R7 strobes exclusive", both, 0);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sclk == pol, "R6 idle level", sclk, pol);
    check(!launch_stb && !sample_stb, "R6 no strobe idle", launch_stb + sample_stb, 0);
  endtask

  task automatic byp_run(input bit pol);
    int bad_lo = 0, bad_hi = 0, bad_stb = 0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (sclk != pol) bad_lo++;
      if (!(launch_stb && sample_stb)) bad_stb++;
      @(posedge clk); #1;
      if (sclk != !pol) bad_hi++;
    end
    check(bad_lo == 0, "R8 bypass low half", bad_lo, 0);
    check(bad_hi == 0, "R8 bypass high half", bad_hi, 0);
    check(bad_stb == 0, "R8 bypass strobes", bad_stb, 0);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sclk == pol && !launch_stb && !sample_stb, "R6 idle after bypass", sclk, pol);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int pres[4] = '{0, 1, 2, 4};
    repeat (3) @(negedge clk);
    check(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    check(!launch_stb && !sample_stb, "R1 reset strobes", launch_stb + sample_stb, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 R5 R7: sweep of small configurations in all four modes
    for (int m = 0; m < 4; m++)
      for (int pi = 0; pi < 4; pi++)
        for (int nm = 1; nm <= 4; nm++)
          for (int hm = 0; hm < nm; hm++) begin
            load_cfg(1'b0, pres[pi], nm, hm, m[1], m[0]);
            check(sclk == m[1], "R2 loaded polarity", sclk, m[1]);
            div_run(pres[pi], nm, hm, m[1], m[0], 1'b0);
          end

    // R2: widest period field and largest prescaler
    load_cfg(1'b0, 0, 63, 31, 1'b0, 1'b0);
    div_run(0, 63, 31, 1'b0, 1'b0, 1'b0);
    load_cfg(1'b0, 8191, 1, 0, 1'b1, 1'b1);
    div_run(8191, 1, 0, 1'b1, 1'b1, 1'b0);

    // R3: load during run ignored, also for the next transfer
    load_cfg(1'b0, 2, 3, 1, 1'b0, 1'b1);
    div_run(2, 3, 1, 1'b0, 1'b1, 1'b1);
    div_run(2, 3, 1, 1'b0, 1'b1, 1'b0);

    // R9: abort mid-period, next transfer restarts from zero
    load_cfg(1'b0, 3, 4, 2, 1'b1, 1'b0);
    run = 1'b1;
    repeat (7) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    div_run(3, 4, 2, 1'b1, 1'b0, 1'b0);
    check(1'b1, "R9 restart exercised", 1, 1);

    // R8: bypass with arbitrary count fields, both polarities
    load_cfg(1'b1, 77, 9, 3, 1'b0, 1'b1);
    byp_run(1'b0);
    load_cfg(1'b1, 5, 2, 1, 1'b1, 1'b0);
    byp_run(1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule